// File: doc/BRIEF.md
# Three-by-three color matrix multiplier

This block multiplies each incoming three-channel pixel by a stored 3x3 matrix of signed fixed-point coefficients. It forms three dot products in parallel, one for each output channel. Typical jobs are color space conversion, for example luma/chroma to RGB, and linear transforms of 3D coordinates. One vector can enter on every clock, and the result appears a fixed number of cycles later together with a valid flag.

Each channel is a signed 12-bit sample. Each coefficient is a signed 10-bit value with 8 fractional bits, so its range is -2.0 to about +1.996. Each dot product is summed at full precision, rounded to an integer and clamped to the 12-bit signed range.

The matrix is reloaded one row per cycle, so a full reload takes three cycles. Rows 0 and 1 go into a staging bank. Writing row 2 moves the whole matrix into use at once. Vectors already in the pipeline finish with the coefficients they entered with, and streaming does not have to pause during a reload.

Top module: `color_matrix_mul`

## Requirements
- R1: After reset, `valid_o` and `pix_o` are zero and every in-use coefficient is zero. A vector accepted before any matrix commit therefore yields zero on all channels.
- R2: A vector presented with `valid_i` high is captured at a rising edge. Its result is on `pix_o` with `valid_o` high after the third rising edge from capture. A new vector is accepted on every cycle.
- R3: Output channel r is the sum over columns c of coefficient(r,c) × input channel c. Input channel c sits at `pix_i[12c+11:12c]`. Output channel r sits at `pix_o[12r+11:12r]`. All values are two's complement, and each coefficient carries 8 fractional bits.
- R4: The full-precision sum is rounded by adding 128 and shifting right arithmetically by 8, so that halves round toward positive infinity.
- R5: A rounded result above 2047 gives 2047, and a result below -2048 gives -2048.
- R6: `coef_load_i` with `coef_row_i` equal to 0 or 1 stores `coef_i` as that staging row. The in-use matrix and all outputs are not affected. Column c of the row sits at `coef_i[10c+9:10c]`.
- R7: `coef_load_i` with `coef_row_i` equal to 2 puts staging rows 0 and 1 and the `coef_i` row into use as rows 0, 1 and 2, all in the same edge. The vector accepted in that same cycle is the first one to use the new matrix. Earlier vectors keep the old one.
- R8: `coef_load_i` with `coef_row_i` equal to 3 changes neither staging nor in-use coefficients.
- R9: While `valid_o` is low, `pix_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vector present |
| pix_i | input | 36 | Three signed 12-bit input channels |
| coef_load_i | input | 1 | Coefficient row write strobe |
| coef_row_i | input | 2 | Row index of the write |
| coef_i | input | 30 | Three signed 10-bit coefficients of one row |
| valid_o | output | 1 | Output vector present |
| pix_o | output | 36 | Three signed 12-bit output channels |

## Verification
Streaming vectors and committing a new matrix can fall in the same cycle. The bench provokes this by holding `valid_i` high on every cycle of a three-cycle reload, and by writing staging rows and the ignored row code in the middle of a stream. A reference model in the bench switches matrices at exactly the vector that arrives with the row 2 write. The bench then compares every output word against it, including the words produced just before and just after the switch, and checks that each word arrives three edges after it was accepted.

// File: rtl/cmm_pkg.sv
package cmm_pkg;
  localparam int unsigned CH       = 3;
  localparam int unsigned ROW_W    = 2;
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(CH - 1);
  localparam int unsigned LATENCY  = 3;
endpackage

// File: rtl/cmm_coef_bank.sv
module cmm_coef_bank
  import cmm_pkg::*;
#(
  parameter int unsigned COEF_W = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [ROW_W-1:0]           row_i,
  input  logic [CH*COEF_W-1:0]       row_data_i,
  output logic [CH*CH*COEF_W-1:0]    coef_o
);
  localparam int unsigned ROW_BITS = CH * COEF_W;

  logic [ROW_BITS-1:0] shd_q [CH-1];
  logic [ROW_BITS-1:0] act_q [CH];

  // staging rows: every row except the last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < CH - 1; r++) shd_q[r] <= '0;
    end else begin
      for (int r = 0; r < CH - 1; r++)
        if (load_i && row_i == ROW_W'(r)) shd_q[r] <= row_data_i;
    end
  end

  // writing the last row commits the whole matrix in one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < CH; r++) act_q[r] <= '0;
    end else if (load_i && row_i == LAST_ROW) begin
      for (int r = 0; r < CH - 1; r++) act_q[r] <= shd_q[r];
      act_q[CH-1] <= row_data_i;
    end
  end

  for (genvar r = 0; r < CH; r++) begin : g_out
    assign coef_o[r*ROW_BITS +: ROW_BITS] = act_q[r];
  end
endmodule

// File: rtl/cmm_dot_lane.sv
module cmm_dot_lane
  import cmm_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned COEF_W = 10,
  parameter int unsigned FRAC_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_prod_i,
  input  logic                   en_out_i,
  input  logic [CH*DATA_W-1:0]   x_i,
  input  logic [CH*COEF_W-1:0]   coef_i,
  output logic [DATA_W-1:0]      y_o
);
  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam int unsigned SUM_W  = PROD_W + $clog2(CH) + 1;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) << (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0] HI   = SUM_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LO   = ~HI;

  logic signed [PROD_W-1:0] prod_q [CH];
  logic signed [SUM_W-1:0]  sum_c, shr_c;
  logic [DATA_W-1:0]        y_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < CH; c++) prod_q[c] <= '0;
    end else if (en_prod_i) begin
      for (int c = 0; c < CH; c++)
        prod_q[c] <= $signed(x_i[c*DATA_W +: DATA_W]) * $signed(coef_i[c*COEF_W +: COEF_W]);
    end
  end

  always_comb begin
    sum_c = '0;
    for (int c = 0; c < CH; c++) sum_c = sum_c + SUM_W'(prod_q[c]);
    shr_c = (sum_c + HALF) >>> FRAC_W;
    if (shr_c > HI)      y_d = DATA_W'(HI);
    else if (shr_c < LO) y_d = DATA_W'(LO);
    else                 y_d = shr_c[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       y_o <= '0;
    else if (en_out_i) y_o <= y_d;
  end
endmodule

// File: rtl/color_matrix_mul.sv
module color_matrix_mul
  import cmm_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned COEF_W = 10,
  parameter int unsigned FRAC_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [CH*DATA_W-1:0]  pix_i,
  input  logic                  coef_load_i,
  input  logic [ROW_W-1:0]      coef_row_i,
  input  logic [CH*COEF_W-1:0]  coef_i,
  output logic                  valid_o,
  output logic [CH*DATA_W-1:0]  pix_o
);
  localparam int unsigned ROW_BITS = CH * COEF_W;

  logic [CH*CH*COEF_W-1:0] coef_act;
  logic [CH*DATA_W-1:0]    pix_q;
  logic                    v1_q, v2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q   <= '0;
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      if (valid_i) pix_q <= pix_i;
      v1_q    <= valid_i;
      v2_q    <= v1_q;
      valid_o <= v2_q;
    end
  end

  cmm_coef_bank #(.COEF_W(COEF_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (coef_load_i),
    .row_i      (coef_row_i),
    .row_data_i (coef_i),
    .coef_o     (coef_act)
  );

  for (genvar r = 0; r < CH; r++) begin : g_lane
    cmm_dot_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_prod_i (v1_q),
      .en_out_i  (v2_q),
      .x_i       (pix_q),
      .coef_i    (coef_act[r*ROW_BITS +: ROW_BITS]),
      .y_o       (pix_o[r*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/cmm_chk.sv
module cmm_chk
  import cmm_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned COEF_W = 10
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic [CH*DATA_W-1:0]     pix_i,
  input logic                     coef_load_i,
  input logic [ROW_W-1:0]         coef_row_i,
  input logic [CH*COEF_W-1:0]     coef_i,
  input logic                     valid_o,
  input logic [CH*DATA_W-1:0]     pix_o,
  input logic [CH*CH*COEF_W-1:0]  coef_act
);
  localparam int unsigned ROW_BITS = CH * COEF_W;

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, 3));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(pix_o));

  assert_stage_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_load_i && coef_row_i < LAST_ROW) |=> $stable(coef_act));

  assert_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_load_i && coef_row_i == 2'd3) |=> $stable(coef_act));

  assert_idle_coef_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !coef_load_i |=> $stable(coef_act));

  assert_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_load_i && coef_row_i == LAST_ROW) |=>
      coef_act[(CH-1)*ROW_BITS +: ROW_BITS] == $past(coef_i));

  assert_zero_in_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && pix_i == '0, 3) |-> pix_o == '0);
endmodule

bind color_matrix_mul cmm_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (.*);

// File: tb/color_matrix_mul_tb.sv
`timescale 1ns/1ps
module color_matrix_mul_tb;
  localparam int DW = 12;
  localparam int CW = 10;
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{0, 0, 0}, '{100, -200, 300}, '{2047, 0, -2048}, '{-1, 1, -1},
    '{512, 512, 512}, '{-700, 1500, 33}, '{1234, -1234, 7}, '{-2048, -2048, 2047}};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, coef_load_i = 1'b0;
  logic [35:0] pix_i = '0;
  logic [1:0]  coef_row_i = '0;
  logic [29:0] coef_i = '0;
  logic        valid_o;
  logic [35:0] pix_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  int shd [2][3];
  int act [3][3];
  int q_y0[$], q_y1[$], q_y2[$], q_due[$];
  string q_req[$];
  string cur_req = "R1";
  logic [35:0] last_pix = '0;

  color_matrix_mul u_dut (.*);

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(string req, int act_v, int exp_v);
    n_run++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  function automatic int ref_ch(int r, int x0, int x1, int x2);
    int s = act[r][0] * x0 + act[r][1] * x1 + act[r][2] * x2;
    s = (s + 128) >>> 8;
    if (s > 2047) s = 2047;
    if (s < -2048) s = -2048;
    return s;
  endfunction

  // one cycle of stimulus; the model switches matrix on the row-2 write
  task automatic step(bit v, int x0, int x1, int x2, bit ld, int row, int c0, int c1, int c2);
    @(posedge clk_i); #1;
    valid_i = v; pix_i = {DW'(x2), DW'(x1), DW'(x0)};
    coef_load_i = ld; coef_row_i = 2'(row); coef_i = {CW'(c2), CW'(c1), CW'(c0)};
    if (ld && row < 2) begin
      shd[row][0] = c0; shd[row][1] = c1; shd[row][2] = c2;
    end else if (ld && row == 2) begin
      for (int c = 0; c < 3; c++) begin
        act[0][c] = shd[0][c]; act[1][c] = shd[1][c];
      end
      act[2][0] = c0; act[2][1] = c1; act[2][2] = c2;
    end
    if (v) begin
      q_y0.push_back(ref_ch(0, x0, x1, x2));
      q_y1.push_back(ref_ch(1, x0, x1, x2));
      q_y2.push_back(ref_ch(2, x0, x1, x2));
      q_due.push_back(cyc + 3);
      q_req.push_back(cur_req);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load(int m [3][3]);
    for (int r = 0; r < 3; r++) step(0, 0, 0, 0, 1, r, m[r][0], m[r][1], m[r][2]);
  endtask

  task automatic stream_table();
    for (int i = 0; i < NV; i++) step(1, VEC[i][0], VEC[i][1], VEC[i][2], 0, 0, 0, 0, 0);
  endtask

  // output monitor: R2 timing, value check, R9 hold
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (valid_o) begin
          if (q_due.size() == 0) check("R2 unexpected valid_o", 1, 0);
          else begin
            string rq = q_req.pop_front();
            check({rq, " ch0"}, int'($signed(pix_o[11:0])), q_y0.pop_front());
            check({rq, " ch1"}, int'($signed(pix_o[23:12])), q_y1.pop_front());
            check({rq, " ch2"}, int'($signed(pix_o[35:24])), q_y2.pop_front());
            check("R2 latency", cyc, q_due.pop_front());
          end
          last_pix = pix_o;
        end else begin
          check("R9 hold", int'(pix_o == last_pix), 1);
          if (q_due.size() != 0 && cyc > q_due[0]) check("R2 missing valid_o", cyc, q_due[0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ident [3][3] = '{'{256, 0, 0}, '{0, 256, 0}, '{0, 0, 256}};
    int mixed [3][3] = '{'{256, 0, 359}, '{256, -88, -183}, '{256, 454, 0}};
    int big   [3][3] = '{'{511, 511, 511}, '{-512, -512, -512}, '{511, 0, 0}};
    int rnd   [3][3] = '{'{1, 0, 0}, '{-1, 0, 0}, '{0, 3, 0}};
    for (int r = 0; r < 2; r++) for (int c = 0; c < 3; c++) shd[r][c] = 0;
    for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) act[r][c] = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid_o after reset", int'(valid_o), 0);
    check("R1 pix_o after reset", int'(pix_o == '0), 1);
    cur_req = "R1";
    step(1, 1000, -1000, 2047, 0, 0, 0, 0, 0);
    idle(4);

    cur_req = "R3";
    load(ident); stream_table(); idle(4);
    load(mixed); stream_table(); idle(4);

    cur_req = "R5";
    load(big); stream_table(); idle(4);

    cur_req = "R4";
    load(rnd);
    step(1, 128, 128, 0, 0, 0, 0, 0, 0);
    step(1, -128, -128, 43, 0, 0, 0, 0, 0);
    step(1, 127, 85, 0, 0, 0, 0, 0, 0);
    step(1, -129, -86, -43, 0, 0, 0, 0, 0);
    step(1, 384, -384, 171, 0, 0, 0, 0, 0);
    idle(4);

    cur_req = "R7";
    for (int i = 0; i < 3; i++) step(1, 300 + i, -50, 900, 0, 0, 0, 0, 0);
    step(1, 400, 400, 400, 1, 0, 256, 0, 0);
    step(1, 500, 500, 500, 1, 1, 0, -256, 0);
    step(1, 600, 700, 800, 1, 2, 128, 128, 128);
    step(1, 601, 701, 801, 0, 0, 0, 0, 0);
    idle(4);

    cur_req = "R6";
    step(1, 1000, 20, -30, 1, 0, 77, 88, 99);
    step(1, 1001, 21, -31, 1, 1, -5, -6, -7);
    step(1, 1002, 22, -32, 0, 0, 0, 0, 0);
    idle(4);

    cur_req = "R8";
    step(1, 10, 20, 30, 1, 3, 500, 500, 500);
    step(1, 11, 21, 31, 1, 2, 256, 256, 256);
    step(1, 12, 22, 32, 1, 3, -500, 1, 1);
    step(1, 13, 23, 33, 0, 0, 0, 0, 0);
    idle(4);

    cur_req = "R9";
    load(mixed);
    for (int i = 0; i < 6; i++) begin
      step(1, VEC[i][0], VEC[i][1], VEC[i][2], 0, 0, 0, 0, 0);
      idle(i % 3);
    end
    idle(6);

    check("R2 drained", q_due.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule